// File: doc/BRIEF.md
# Epoch Crossbar Switch Allocator

This block decides, once per fixed-length epoch, which source port of a point-to-point switch may send to which destination port. Every source presents a request bit for each destination it holds data for. Every destination presents an inhibit bit that blocks new transfers toward it. The allocator builds a one-to-one pairing, so each source gets at most one destination and each destination at most one source. Ports marked as forwarding engines are served before line-card ports. A pseudo-random rotation of the scan order is applied each epoch so that no port number is favoured over time.

Scheduling follows a four-epoch pipeline. Requests and inhibits presented during epoch E are sampled at its last cycle. The pairing is computed during E+1 and announced on the grant outputs for the whole of E+2. The same pairing appears on the transfer outputs for the whole of E+3, where it drives the data crossbar. Successive epochs overlap, so a new pairing is produced every epoch.

The block has no valid/ready handshake. Requests are levels that a source holds until it sees its grant. Back-pressure comes only from the per-destination inhibit bits.

Top module: `xbar_epoch_alloc`

## Requirements
- R1: An epoch is EPOCH_TICKS clock cycles long (default 8). `epoch_start_o` is high in the first cycle of every epoch, including the first cycle after reset, and low in all other cycles.
- R2: The pairing computed from requests sampled in the last cycle of epoch E is shown on the grant outputs throughout epoch E+2. It is shown on the transfer outputs throughout epoch E+3.
- R3: Source s is granted destination d only if request bit s*NPORTS+d was set and inhibit bit d was clear when the requests were sampled. Source s's destination index sits in `grant_dest_o[s*4 +: 4]`, qualified by `grant_valid_o[s]`.
- R4: No destination is granted to more than one source in an epoch. When requests allow it, all 15 sources may be granted together.
- R5: A source that is left ungranted has no requested, non-inhibited destination that remains free.
- R6: Sources whose bit is set in FE_MASK (default bits 3, 7, 11 and 14) are all considered before any other source. A forwarding-engine source that competes with a line-card source for the same single destination wins.
- R7: The scan order is set by an offset r. A 16-bit LFSR starts from LFSR_SEED (default 16'hACE1). Each step shifts left and feeds in bit15^bit13^bit12^bit10 at bit 0, and the LFSR steps once at the end of every epoch. r is the LFSR's low 4 bits, with the value 15 mapped to 0. Allocation number n (counting from 0 at the end of the first epoch) uses the state after n steps. Within each class, sources are visited in the order (k+r) mod 15. Each source takes the first eligible destination in the order (j+r) mod 15.
- R8: Grant outputs do not change within an epoch. The destination field of a source without a grant reads 0.
- R9: After reset, all grant and transfer valid bits and destination fields are 0.
- R10: The block keeps no memory of requests that lost. A request held over several epochs is decided afresh each epoch and is granted once its competitor is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Allocation clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NPORTS*NPORTS | Request matrix, bit s*NPORTS+d = source s wants destination d |
| inhibit_i | input | NPORTS | Per-destination flow-control stop |
| epoch_start_o | output | 1 | High in the first cycle of each epoch |
| grant_valid_o | output | NPORTS | Per-source grant for the notification epoch |
| grant_dest_o | output | NPORTS*4 | Per-source granted destination index |
| xfer_valid_o | output | NPORTS | Per-source grant for the transfer epoch |
| xfer_dest_o | output | NPORTS*4 | Per-source destination for the transfer epoch |

## Verification
The pairing logic is exercised with four directed request shapes.

- Every source asking for a single destination shows that only one grant is given and that it goes to a forwarding engine.
- Full requests with every destination inhibited show that inhibit overrides demand.
- A full permutation shows that all 15 pairs can be granted at once.
- A held two-way conflict, followed by removal of the winner, separates class priority from re-evaluation.

Random request matrices with sparse inhibits are then compared each epoch against a bench model of the rotated two-class scan. This tells apart errors in the rotation offset, the LFSR sequence and the destination preference order, which the directed cases alone cannot reach. Legality and one-to-one pairing are also checked on their own terms against the recorded requests.

// File: rtl/xalloc_pkg.sv
package xalloc_pkg;
  localparam int LFSR_W = 16;

  // Advance the scan-offset generator by one epoch.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Position k of a ring of n entries, starting at off.
  function automatic int ring_pos(input int k, input int off, input int n);
    int t;
    t = k + off;
    return (t >= n) ? t - n : t;
  endfunction
endpackage

// File: rtl/xalloc_epoch_timer.sv
module xalloc_epoch_timer #(
  parameter int EPOCH_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic epoch_start_o,
  output logic epoch_last_o
);
  localparam int CW = (EPOCH_TICKS > 1) ? $clog2(EPOCH_TICKS) : 1;

  logic [CW-1:0] tick_q;

  assign epoch_start_o = (tick_q == '0);
  assign epoch_last_o  = (tick_q == CW'(EPOCH_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)            tick_q <= '0;
    else if (epoch_last_o) tick_q <= '0;
    else                   tick_q <= tick_q + CW'(1);
  end

  // R1: an epoch boundary is always followed by a fresh epoch start
  assert_epoch_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_last_o |=> epoch_start_o);

  generate
    if (EPOCH_TICKS > 1) begin : g_multi
      // R1: no start pulse in the middle of an epoch
      assert_no_mid_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch_last_o |=> !epoch_start_o);
    end
  endgenerate
endmodule

// File: rtl/xalloc_shuffle.sv
module xalloc_shuffle
  import xalloc_pkg::*;
#(
  parameter int                NPORTS    = 15,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      advance_i,
  output logic [$clog2(NPORTS)-1:0] offset_o
);
  localparam int IDX_W = $clog2(NPORTS);

  logic [LFSR_W-1:0] lfsr_q;
  logic [IDX_W-1:0]  raw;

  always_ff @(posedge clk) begin
    if (!rst_n)         lfsr_q <= LFSR_SEED;
    else if (advance_i) lfsr_q <= lfsr_step(lfsr_q);
  end

  assign raw      = lfsr_q[IDX_W-1:0];
  assign offset_o = ({1'b0, raw} >= (IDX_W+1)'(NPORTS)) ? raw - IDX_W'(NPORTS) : raw;

  // R7: generator never locks up in the all-zero state
  assert_lfsr_alive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  // R7: the offset always names a real port
  assert_offset_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, offset_o} < (IDX_W+1)'(NPORTS));
endmodule

// File: rtl/xalloc_match.sv
module xalloc_match
  import xalloc_pkg::*;
#(
  parameter int                NPORTS  = 15,
  parameter logic [NPORTS-1:0] FE_MASK = 15'h4888
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NPORTS*NPORTS-1:0]         req_i,
  input  logic [NPORTS-1:0]                inh_i,
  input  logic [$clog2(NPORTS)-1:0]        offset_i,
  output logic [NPORTS-1:0]                gnt_valid_o,
  output logic [NPORTS*$clog2(NPORTS)-1:0] gnt_dest_o
);
  localparam int IDX_W = $clog2(NPORTS);

  logic [NPORTS-1:0] taken_c;
  int                src_c, dst_c;

  // Two-class greedy scan over rotated source and destination orders.
  always_comb begin
    taken_c     = '0;
    gnt_valid_o = '0;
    gnt_dest_o  = '0;
    src_c       = 0;
    dst_c       = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < NPORTS; k++) begin
        src_c = ring_pos(k, int'(offset_i), NPORTS);
        if (FE_MASK[src_c] == (pass == 0)) begin
          for (int j = 0; j < NPORTS; j++) begin
            dst_c = ring_pos(j, int'(offset_i), NPORTS);
            if (!gnt_valid_o[src_c] && req_i[src_c*NPORTS + dst_c] &&
                !inh_i[dst_c] && !taken_c[dst_c]) begin
              gnt_valid_o[src_c]                  = 1'b1;
              taken_c[dst_c]                      = 1'b1;
              gnt_dest_o[src_c*IDX_W +: IDX_W]    = IDX_W'(dst_c);
            end
          end
        end
      end
    end
  end

  // Checker helpers rebuilt from the outputs.
  logic [NPORTS-1:0] dest_union, fe_hungry;
  always_comb begin
    dest_union = '0;
    fe_hungry  = '0;
    for (int s = 0; s < NPORTS; s++) begin
      if (gnt_valid_o[s]) dest_union[gnt_dest_o[s*IDX_W +: IDX_W]] = 1'b1;
      if (FE_MASK[s] && !gnt_valid_o[s]) fe_hungry = fe_hungry | (req_i[s*NPORTS +: NPORTS] & ~inh_i);
    end
  end

  // R4: destinations used equal grants issued, so no destination is shared
  assert_one_to_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dest_union) == $countones(gnt_valid_o));

  generate
    for (genvar s = 0; s < NPORTS; s++) begin : g_src
      // R3: grants only for requested, open destinations
      assert_grant_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o[s] |-> (req_i[s*NPORTS + int'(gnt_dest_o[s*IDX_W +: IDX_W])] &&
                            !inh_i[gnt_dest_o[s*IDX_W +: IDX_W]]));
      // R5: a loser has nothing eligible left
      assert_maximal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid_o[s] |-> ((req_i[s*NPORTS +: NPORTS] & ~inh_i & ~dest_union) == '0));
      if (!FE_MASK[s]) begin : g_lc
        // R6: a line card never takes a destination an unserved engine wanted
        assert_fe_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
          gnt_valid_o[s] |-> !fe_hungry[gnt_dest_o[s*IDX_W +: IDX_W]]);
      end
    end
  endgenerate
endmodule

// File: rtl/xbar_epoch_alloc.sv
module xbar_epoch_alloc
  import xalloc_pkg::*;
#(
  parameter int                NPORTS      = 15,
  parameter int                EPOCH_TICKS = 8,
  parameter logic [NPORTS-1:0] FE_MASK     = 15'h4888,
  parameter logic [LFSR_W-1:0] LFSR_SEED   = 16'hACE1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NPORTS*NPORTS-1:0]         req_i,
  input  logic [NPORTS-1:0]                inhibit_i,
  output logic                             epoch_start_o,
  output logic [NPORTS-1:0]                grant_valid_o,
  output logic [NPORTS*$clog2(NPORTS)-1:0] grant_dest_o,
  output logic [NPORTS-1:0]                xfer_valid_o,
  output logic [NPORTS*$clog2(NPORTS)-1:0] xfer_dest_o
);
  localparam int IDX_W = $clog2(NPORTS);
  localparam int NREQ  = NPORTS * NPORTS;

  logic                      epoch_last;
  logic [IDX_W-1:0]          offset;
  logic [NREQ-1:0]           req_q;
  logic [NPORTS-1:0]         inh_q;
  logic [NPORTS-1:0]         m_valid;
  logic [NPORTS*IDX_W-1:0]   m_dest;

  xalloc_epoch_timer #(.EPOCH_TICKS(EPOCH_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .epoch_start_o(epoch_start_o), .epoch_last_o(epoch_last)
  );

  xalloc_shuffle #(.NPORTS(NPORTS), .LFSR_SEED(LFSR_SEED)) u_shuffle (
    .clk(clk), .rst_n(rst_n), .advance_i(epoch_last), .offset_o(offset)
  );

  xalloc_match #(.NPORTS(NPORTS), .FE_MASK(FE_MASK)) u_match (
    .clk(clk), .rst_n(rst_n), .req_i(req_q), .inh_i(inh_q), .offset_i(offset),
    .gnt_valid_o(m_valid), .gnt_dest_o(m_dest)
  );

  // Request, allocate, notify, transfer: each stage advances at epoch end.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q         <= '0;
      inh_q         <= '0;
      grant_valid_o <= '0;
      grant_dest_o  <= '0;
      xfer_valid_o  <= '0;
      xfer_dest_o   <= '0;
    end else if (epoch_last) begin
      req_q         <= req_i;
      inh_q         <= inhibit_i;
      grant_valid_o <= m_valid;
      grant_dest_o  <= m_dest;
      xfer_valid_o  <= grant_valid_o;
      xfer_dest_o   <= grant_dest_o;
    end
  end

  // R2: transfer configuration is last epoch's announcement
  assert_xfer_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_last |=> (xfer_valid_o == $past(grant_valid_o) && xfer_dest_o == $past(grant_dest_o)));
  // R8: announcement held for the whole epoch
  assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_last |=> ($stable(grant_valid_o) && $stable(grant_dest_o)));
  // R2: sampled requests frozen while allocation uses them
  assert_req_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_last |=> ($stable(req_q) && $stable(inh_q)));
endmodule

// File: tb/xbar_epoch_alloc_tb.sv
module xbar_epoch_alloc_tb;
  localparam int N   = 15;
  localparam int W   = 4;
  localparam int NN  = N * N;
  localparam int EP  = 8;
  localparam int NEP = 120;
  localparam logic [N-1:0] FEM  = 15'h4888;
  localparam logic [15:0]  SEED = 16'hACE1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NN-1:0]   req_i = '0;
  logic [N-1:0]    inhibit_i = '0;
  logic            epoch_start_o;
  logic [N-1:0]    grant_valid_o, xfer_valid_o;
  logic [N*W-1:0]  grant_dest_o, xfer_dest_o;

  always #10 clk = ~clk;

  xbar_epoch_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .inhibit_i(inhibit_i),
    .epoch_start_o(epoch_start_o), .grant_valid_o(grant_valid_o), .grant_dest_o(grant_dest_o),
    .xfer_valid_o(xfer_valid_o), .xfer_dest_o(xfer_dest_o)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string rq, input logic [NN-1:0] act, input logic [NN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] lf_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Reference pairing built from R6/R7.
  function automatic void model(input logic [NN-1:0] rq, input logic [N-1:0] ih, input logic [15:0] lf,
                                output logic [N-1:0] gv, output logic [N*W-1:0] gd);
    logic [N-1:0] used;
    int r, s, d;
    r = int'(lf[3:0]);
    if (r == 15) r = 0;
    gv = '0; gd = '0; used = '0;
    for (int cls = 1; cls >= 0; cls--) begin
      for (int k = 0; k < N; k++) begin
        s = (k + r) % N;
        if (int'(FEM[s]) == cls) begin
          for (int j = 0; j < N; j++) begin
            d = (j + r) % N;
            if (!gv[s] && rq[s*N + d] && !ih[d] && !used[d]) begin
              gv[s] = 1'b1; used[d] = 1'b1; gd[s*W +: W] = W'(d);
            end
          end
        end
      end
    end
  endfunction

  logic [NN-1:0] req_h [NEP];
  logic [N-1:0]  inh_h [NEP];
  int            pat_h [NEP];

  initial begin : watchdog
    repeat (NEP * EP + 200) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0]    lf;
    logic [NN-1:0]  prev_req, rq;
    logic [N-1:0]   prev_inh, ih, exp_gv, exp_xv, ngv, used;
    logic [N*W-1:0] exp_gd, exp_xd, ngd;
    int             pat, d;
    bit             ok;
    void'($urandom(32'd2024));
    lf = SEED; prev_req = '0; prev_inh = '0;
    exp_gv = '0; exp_gd = '0; exp_xv = '0; exp_xd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk(grant_valid_o == '0 && grant_dest_o == '0, "R9 grant reset", NN'(grant_dest_o), '0);
    chk(xfer_valid_o == '0 && xfer_dest_o == '0, "R9 xfer reset", NN'(xfer_dest_o), '0);
    for (int n = 0; n < NEP; n++) begin
      chk(epoch_start_o == 1'b1, "R1 epoch start", NN'(epoch_start_o), NN'(1));
      chk(grant_valid_o == exp_gv && grant_dest_o == exp_gd, "R7 grant vs model",
          NN'({grant_valid_o, grant_dest_o}), NN'({exp_gv, exp_gd}));
      chk(xfer_valid_o == exp_xv && xfer_dest_o == exp_xd, "R2 xfer pipeline",
          NN'({xfer_valid_o, xfer_dest_o}), NN'({exp_xv, exp_xd}));
      if (n >= 2) begin
        ok = 1; used = '0;
        for (int s = 0; s < N; s++) begin
          if (grant_valid_o[s]) begin
            d = int'(grant_dest_o[s*W +: W]);
            if (d >= N || !req_h[n-2][s*N + d] || inh_h[n-2][d] || used[d]) ok = 0;
            else used[d] = 1'b1;
          end
        end
        chk(ok, "R3/R4 legal one-to-one", NN'(grant_dest_o), '0);
        case (pat_h[n-2])
          1: begin
            ok = ($countones(grant_valid_o) == 1) && ((grant_valid_o & ~FEM) == '0);
            chk(ok, "R6 single dest to engine", NN'(grant_valid_o), NN'(FEM));
          end
          2: chk(grant_valid_o == '0, "R3 all inhibited", NN'(grant_valid_o), '0);
          3: chk(grant_valid_o == '1, "R4 full permutation", NN'(grant_valid_o), NN'({N{1'b1}}));
          4: chk(grant_valid_o == N'(1 << 3) && grant_dest_o[3*W +: W] == 4'd9, "R6 engine beats line card",
                 NN'(grant_valid_o), NN'(1 << 3));
          5: chk(grant_valid_o == N'(1) && grant_dest_o[0 +: W] == 4'd9, "R10 held request granted",
                 NN'(grant_valid_o), NN'(1));
          default: ;
        endcase
      end
      // stimulus for this epoch
      if (n < 3) pat = 1;
      else if (n < 5) pat = 2;
      else if (n < 8) pat = 3;
      else if (n < 11) pat = 4;
      else if (n < 13) pat = 5;
      else if (n >= 60 && n < 62) pat = 3;
      else pat = 0;
      rq = '0; ih = '0;
      case (pat)
        1: for (int s = 0; s < N; s++) rq[s*N + 5] = 1'b1;
        2: begin rq = '1; ih = '1; end
        3: for (int s = 0; s < N; s++) rq[s*N + ((s + 3) % N)] = 1'b1;
        4: begin rq[0*N + 9] = 1'b1; rq[3*N + 9] = 1'b1; end
        5: rq[0*N + 9] = 1'b1;
        default: begin
          for (int s = 0; s < N; s++)
            if ($urandom % 3 != 0)
              for (int t = 0; t < 1 + int'($urandom % 3); t++) rq[s*N + int'($urandom % N)] = 1'b1;
          for (int dd = 0; dd < N; dd++) ih[dd] = ($urandom % 6 == 0);
        end
      endcase
      req_i = rq; inhibit_i = ih;
      req_h[n] = rq; inh_h[n] = ih; pat_h[n] = pat;
      repeat (EP / 2) @(negedge clk);
      chk(epoch_start_o == 1'b0, "R1 no mid start", NN'(epoch_start_o), '0);
      chk(grant_valid_o == exp_gv && grant_dest_o == exp_gd, "R8 grant held",
          NN'({grant_valid_o, grant_dest_o}), NN'({exp_gv, exp_gd}));
      repeat (EP - EP / 2) @(negedge clk);
      model(prev_req, prev_inh, lf, ngv, ngd);
      lf = lf_next(lf);
      exp_xv = exp_gv; exp_xd = exp_gd;
      exp_gv = ngv;    exp_gd = ngd;
      prev_req = rq;   prev_inh = ih;
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule